// File: doc/BRIEF.md
# UART Transmit Queue and Shifter Sequencer

This block is the transmit half of a 16550-class serial port. Host writes land either in a single holding register or, when the queue mode is on, in a 16-deep first-in first-out store. A three-state sequencer moves one byte at a time from there into a transmit shift register. It offers that byte to an external bit serializer and waits for the serializer to report that shifting has finished. The block keeps the holding-empty flag (THRE), the transmitter-empty flag (TEMT) and the transmit interrupt request.

In internal loopback the serializer still paces each byte, but it is told to keep the line idle. When the byte finishes, it is handed to the receive path on a separate one-cycle strobe instead of going out on the line. Two controls discard queued bytes. One is a clear pulse. The other is any change of the queue-mode input, which also forces both empty flags and the interrupt high.

The sequencer states are TX_IDLE (nothing in the shifter), TX_OFFER (the shifter byte is offered with `ser_valid`) and TX_SHIFT (the serializer is shifting). It has four transitions:

- **load**: TX_IDLE to TX_OFFER, taken when a byte is queued.
- **accept**: TX_OFFER to TX_SHIFT, taken on `ser_ready`.
- **reload**: TX_SHIFT to TX_OFFER, taken on `ser_done` when another byte is queued. It moves that byte in at the same edge.
- **drain**: TX_SHIFT to TX_IDLE, taken on `ser_done` when nothing is queued.

Top module: `uart_tx_ctrl`

## Requirements
- R1: After reset, `thre` and `temt` are 1, `tx_irq` is 0, `tx_level` is 0 and `ser_valid` is 0.
- R2: With `fifo_en` high, up to 16 bytes wait in the queue and leave in write order. A write arriving while `tx_level` is 16 is discarded, and `tx_level` stays 16.
- R3: An accepted host write clears `thre`, `temt` and `tx_irq` at the edge that takes it.
- R4: A move into the shifter clears `temt`. While `ser_valid` is high and `ser_ready` is low, `ser_valid` stays high and `ser_data` stays unchanged.
- R5: In queue mode, `thre` and `tx_irq` are set only by the move that leaves the queue empty. While bytes remain queued, `thre` stays 0.
- R6: With `fifo_en` low there is one holding register, so `tx_level` is at most 1. A write while it is occupied replaces the byte. Every move sets `thre` and `tx_irq`.
- R7: On `ser_done`, a queued byte is moved in at the same edge, so `ser_valid` is high in the next cycle. If nothing is queued, the sequencer returns to idle and `temt` takes the value of `thre`.
- R8: With `loopback` high when a byte is moved in, `ser_quiet` is 1 while that byte is in flight. The cycle after its `ser_done`, `lb_valid` pulses for one cycle with the byte on `lb_data`.
- R9: A `tx_clear` pulse empties the queue and sets `thre`, and leaves `temt` and `tx_irq` unchanged. A write in the same cycle is dropped.
- R10: A change of `fifo_en` empties the queue and sets `thre`, `temt` and `tx_irq`. A write in the same cycle is dropped.
- R11: `temt` is never 1 while `thre` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fifo_en | input | 1 | Queue mode select; a change flushes the queue |
| tx_clear | input | 1 | Pulse: discard queued bytes |
| host_wr | input | 1 | Host write strobe to the transmit register |
| host_data | input | DATA_W | Host write byte |
| loopback | input | 1 | Route finished bytes to the receive path |
| ser_valid | output | 1 | Shifter byte offered to the serializer |
| ser_data | output | DATA_W | Shifter byte |
| ser_quiet | output | 1 | Serializer must hold the line idle for this byte |
| ser_ready | input | 1 | Serializer takes the offered byte |
| ser_done | input | 1 | Pulse: serializer finished shifting |
| lb_valid | output | 1 | One-cycle strobe of a looped-back byte |
| lb_data | output | DATA_W | Looped-back byte |
| thre | output | 1 | Holding register or queue empty |
| temt | output | 1 | Holding side and shifter both empty |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_level | output | $clog2(DEPTH+1) | Bytes waiting in the queue or holding register |

## Verification
The bench builds the block with the default parameters: an 8-bit data width and a depth of 16. With these values, a 17-write burst against a stalled serializer fills the queue to exactly its limit, counting the byte already in the shifter, and the 18th write then probes the drop rule. A serializer model with a fixed shift time exposes the reload-at-done path on every byte of that burst. The 8-entry midpoint lets the bench confirm that the holding-empty flag stays low until the final move.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_OFFER = 2'd1,
        TX_SHIFT = 2'd2
    } tx_state_e;

endpackage

// File: rtl/uart_tx_queue.sv
module uart_tx_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_mode,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] hold_q;
    logic              push_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // In queue mode a full store refuses the byte; the holding register always takes it.
    assign push_ok = push && !flush && (!fifo_mode || (cnt_q != CNT_W'(DEPTH)));

    always_ff @(posedge clk) begin
        if (push_ok && fifo_mode)
            mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
            hold_q <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (fifo_mode) begin
            if (push_ok)
                wr_ptr <= bump(wr_ptr);
            if (pop)
                rd_ptr <= bump(rd_ptr);
            unique case ({push_ok, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end else begin
            if (push_ok)
                hold_q <= push_data;
            if (push_ok)
                cnt_q <= CNT_W'(1);
            else if (pop)
                cnt_q <= '0;
        end
    end

    assign head  = fifo_mode ? mem[rd_ptr] : hold_q;
    assign count = cnt_q;

    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(DEPTH));

    a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt_q != '0));

    a_r6_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> (cnt_q <= CNT_W'(1)));

endmodule

// File: rtl/uart_tx_seq.sv
module uart_tx_seq
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_eff,
    input  logic              toggle,
    input  logic              clr,
    input  logic              fifo_mode,
    input  logic [CNT_W-1:0]  count,
    input  logic [DATA_W-1:0] head,
    input  logic              loopback,
    input  logic              ser_ready,
    input  logic              ser_done,
    output logic              pop,
    output logic              ser_valid,
    output logic [DATA_W-1:0] ser_data,
    output logic              ser_quiet,
    output logic              lb_valid,
    output logic [DATA_W-1:0] lb_data,
    output logic              thre,
    output logic              temt,
    output logic              tx_irq
);

    tx_state_e         state_q, state_d;
    logic [DATA_W-1:0] shift_q;
    logic              lb_sel_q;
    logic              lb_valid_q;
    logic [DATA_W-1:0] lb_data_q;
    logic              thre_q, temt_q, irq_q;
    logic              thre_d, temt_d, irq_d;
    logic              can_move, finished, thre_set;

    assign can_move = (count != '0) && !toggle && !clr;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= TX_IDLE;
        else
            state_q <= state_d;
    end

    // Next state and outputs
    always_comb begin
        state_d  = state_q;
        pop      = 1'b0;
        finished = 1'b0;
        unique case (state_q)
            TX_IDLE: begin
                if (can_move) begin
                    pop     = 1'b1;
                    state_d = TX_OFFER;       // load
                end
            end
            TX_OFFER: begin
                if (ser_ready)
                    state_d = TX_SHIFT;       // accept
            end
            TX_SHIFT: begin
                if (ser_done) begin
                    finished = 1'b1;
                    if (can_move) begin
                        pop     = 1'b1;
                        state_d = TX_OFFER;   // reload
                    end else begin
                        state_d = TX_IDLE;    // drain
                    end
                end
            end
            default: state_d = TX_IDLE;
        endcase
    end

    assign ser_valid = (state_q == TX_OFFER);

    // Holding side empties on the move that takes its last byte
    assign thre_set = pop && !wr_eff && (!fifo_mode || (count == CNT_W'(1)));

    always_comb begin
        thre_d = thre_q;
        if (toggle || clr)
            thre_d = 1'b1;
        else if (wr_eff)
            thre_d = 1'b0;
        else if (thre_set)
            thre_d = 1'b1;

        irq_d = irq_q;
        if (toggle)
            irq_d = 1'b1;
        else if (wr_eff)
            irq_d = 1'b0;
        else if (thre_set)
            irq_d = 1'b1;

        temt_d = temt_q;
        if (toggle)
            temt_d = 1'b1;
        else if (wr_eff || pop)
            temt_d = 1'b0;
        else if (finished)
            temt_d = thre_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            thre_q     <= 1'b1;
            temt_q     <= 1'b1;
            irq_q      <= 1'b0;
            shift_q    <= '0;
            lb_sel_q   <= 1'b0;
            lb_valid_q <= 1'b0;
            lb_data_q  <= '0;
        end else begin
            thre_q     <= thre_d;
            temt_q     <= temt_d;
            irq_q      <= irq_d;
            lb_valid_q <= finished && lb_sel_q;
            if (finished && lb_sel_q)
                lb_data_q <= shift_q;
            if (pop) begin
                shift_q  <= head;
                lb_sel_q <= loopback;
            end
        end
    end

    assign ser_data  = shift_q;
    assign ser_quiet = lb_sel_q;
    assign lb_valid  = lb_valid_q;
    assign lb_data   = lb_data_q;
    assign thre      = thre_q;
    assign temt      = temt_q;
    assign tx_irq    = irq_q;

    a_r3_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        wr_eff |=> (!thre && !temt && !tx_irq));

    a_r4_move_clears_temt: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !toggle) |=> !temt);

    a_r8_lb_single: assert property (@(posedge clk) disable iff (!rst_n)
        lb_valid |=> !lb_valid);

    a_r7_reload_offers: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TX_SHIFT && ser_done && can_move) |=> ser_valid);

endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fifo_en,
    input  logic              tx_clear,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              loopback,
    output logic              ser_valid,
    output logic [DATA_W-1:0] ser_data,
    output logic              ser_quiet,
    input  logic              ser_ready,
    input  logic              ser_done,
    output logic              lb_valid,
    output logic [DATA_W-1:0] lb_data,
    output logic              thre,
    output logic              temt,
    output logic              tx_irq,
    output logic [CNT_W-1:0]  tx_level
);

    logic              mode_q;
    logic              toggle, wr_eff, flush, pop;
    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= 1'b0;
        else
            mode_q <= fifo_en;
    end

    assign toggle = (fifo_en != mode_q);
    assign flush  = toggle || tx_clear;
    assign wr_eff = host_wr && !flush;

    uart_tx_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .fifo_mode (mode_q),
        .flush     (flush),
        .push      (wr_eff),
        .push_data (host_data),
        .pop       (pop),
        .head      (head),
        .count     (count)
    );

    uart_tx_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_eff    (wr_eff),
        .toggle    (toggle),
        .clr       (tx_clear),
        .fifo_mode (mode_q),
        .count     (count),
        .head      (head),
        .loopback  (loopback),
        .ser_ready (ser_ready),
        .ser_done  (ser_done),
        .pop       (pop),
        .ser_valid (ser_valid),
        .ser_data  (ser_data),
        .ser_quiet (ser_quiet),
        .lb_valid  (lb_valid),
        .lb_data   (lb_data),
        .thre      (thre),
        .temt      (temt),
        .tx_irq    (tx_irq)
    );

    assign tx_level = count;

    a_r11_temt_implies_thre: assert property (@(posedge clk) disable iff (!rst_n)
        temt |-> thre);

    a_r4_offer_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && !ser_ready) |=> (ser_valid && $stable(ser_data)));

    a_r10_toggle_status: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (thre && temt && tx_irq && tx_level == '0));

    a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        tx_clear |=> (thre && tx_level == '0));

endmodule

// File: tb/test_uart_tx_ctrl.sv
module test_uart_tx_ctrl;

    localparam int DW    = 8;
    localparam int DEPTH = 16;
    localparam int LW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_en = 1'b0, tx_clear = 1'b0, host_wr = 1'b0, loopback = 1'b0;
    logic [DW-1:0] host_data = '0;
    logic          ser_ready = 1'b0, ser_done = 1'b0;
    logic          ser_valid, ser_quiet, lb_valid, thre, temt, tx_irq;
    logic [DW-1:0] ser_data, lb_data;
    logic [LW-1:0] tx_level;

    int checks = 0;
    int errs   = 0;
    logic [DW-1:0] exp_q[$];
    logic stall    = 1'b1;
    logic mon_busy = 1'b0;

    always #4 clk = ~clk;

    uart_tx_ctrl #(.DATA_W(DW), .DEPTH(DEPTH)) i_uart_tx_ctrl (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_clear(tx_clear),
        .host_wr(host_wr), .host_data(host_data), .loopback(loopback),
        .ser_valid(ser_valid), .ser_data(ser_data), .ser_quiet(ser_quiet),
        .ser_ready(ser_ready), .ser_done(ser_done), .lb_valid(lb_valid),
        .lb_data(lb_data), .thre(thre), .temt(temt), .tx_irq(tx_irq),
        .tx_level(tx_level)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // mode 0: byte expected on output, 1: byte will be lost, 2: replaces last expected
    task automatic host_write(input logic [DW-1:0] d, input int mode);
        @(negedge clk);
        host_wr   = 1'b1;
        host_data = d;
        if (mode == 2 && exp_q.size() > 0)
            void'(exp_q.pop_back());
        if (mode != 1)
            exp_q.push_back(d);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic wait_idle();
        bit done = 1'b0;
        for (int i = 0; i < 3000 && !done; i++) begin
            @(negedge clk);
            if (!mon_busy && !ser_valid && temt && tx_level == '0 && !lb_valid)
                done = 1'b1;
        end
        check("R7", "drain reached idle", {31'b0, done}, 32'd1);
    endtask

    // Serializer model and scoreboard monitor for the line side
    initial begin
        logic [LW-1:0] lvl;
        forever begin
            @(negedge clk);
            if (ser_valid && !stall) begin
                mon_busy = 1'b1;
                if (!ser_quiet) begin
                    if (exp_q.size() == 0)
                        check("R2", "unexpected line byte", {24'b0, ser_data}, 32'hFFFF_FFFF);
                    else
                        check("R2", "line byte order", {24'b0, ser_data}, {24'b0, exp_q.pop_front()});
                end
                ser_ready = 1'b1;
                @(negedge clk);
                ser_ready = 1'b0;
                repeat (3) @(negedge clk);
                lvl = tx_level;
                ser_done = 1'b1;
                @(negedge clk);
                ser_done = 1'b0;
                if (lvl != '0)
                    check("R7", "reload offers next byte", {31'b0, ser_valid}, 32'd1);
                else
                    check("R7", "temt follows thre at drain", {31'b0, temt}, {31'b0, thre});
                mon_busy = 1'b0;
            end
        end
    end

    // Scoreboard monitor for the loopback side
    initial begin
        forever begin
            @(negedge clk);
            if (lb_valid) begin
                if (exp_q.size() == 0)
                    check("R8", "unexpected loop byte", {24'b0, lb_data}, 32'hFFFF_FFFF);
                else
                    check("R8", "loop byte order", {24'b0, lb_data}, {24'b0, exp_q.pop_front()});
            end
        end
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL watchdog: actual expired expected finish");
        summary();
        $finish;
    end

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1", "thre", {31'b0, thre}, 32'd1);
        check("R1", "temt", {31'b0, temt}, 32'd1);
        check("R1", "irq", {31'b0, tx_irq}, 32'd0);
        check("R1", "level", {27'b0, tx_level}, 32'd0);
        check("R1", "ser_valid", {31'b0, ser_valid}, 32'd0);

        // Holding-register mode (R3, R4, R6)
        stall = 1'b1;
        host_write(8'hA5, 0);
        check("R3", "thre after write", {31'b0, thre}, 32'd0);
        check("R3", "temt after write", {31'b0, temt}, 32'd0);
        check("R3", "irq after write", {31'b0, tx_irq}, 32'd0);
        @(negedge clk);
        check("R6", "thre after move", {31'b0, thre}, 32'd1);
        check("R6", "irq after move", {31'b0, tx_irq}, 32'd1);
        check("R4", "temt after move", {31'b0, temt}, 32'd0);
        check("R4", "offer valid", {31'b0, ser_valid}, 32'd1);
        host_write(8'h3C, 0);
        check("R6", "holding occupied", {27'b0, tx_level}, 32'd1);
        check("R3", "irq cleared", {31'b0, tx_irq}, 32'd0);
        repeat (3) @(negedge clk);
        check("R4", "offer held", {31'b0, ser_valid}, 32'd1);
        check("R4", "offer data held", {24'b0, ser_data}, 32'hA5);
        host_write(8'h77, 2);
        check("R6", "overwrite keeps one", {27'b0, tx_level}, 32'd1);
        stall = 1'b0;
        wait_idle();
        check("R7", "temt at end", {31'b0, temt}, 32'd1);
        check("R6", "irq after last move", {31'b0, tx_irq}, 32'd1);

        // Mode change flushes and forces status (R10)
        stall = 1'b1;
        host_write(8'hB1, 0);
        @(negedge clk);
        host_write(8'hB2, 1);
        check("R3", "irq before toggle", {31'b0, tx_irq}, 32'd0);
        fifo_en = 1'b1;
        @(negedge clk);
        check("R10", "thre", {31'b0, thre}, 32'd1);
        check("R10", "temt", {31'b0, temt}, 32'd1);
        check("R10", "irq", {31'b0, tx_irq}, 32'd1);
        check("R10", "level", {27'b0, tx_level}, 32'd0);
        stall = 1'b0;
        wait_idle();

        // Queue mode fill, drop and drain (R2, R5)
        stall = 1'b1;
        for (int i = 0; i < DEPTH + 1; i++)
            host_write(8'h10 + 8'(i), 0);
        check("R2", "level full", {27'b0, tx_level}, DEPTH);
        check("R5", "thre while queued", {31'b0, thre}, 32'd0);
        host_write(8'hEE, 1);
        check("R2", "level after dropped write", {27'b0, tx_level}, DEPTH);
        stall = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (tx_level == LW'(8)) begin
                seen = 1'b1;
                check("R5", "thre low mid-drain", {31'b0, thre}, 32'd0);
                check("R5", "irq low mid-drain", {31'b0, tx_irq}, 32'd0);
            end
        end
        seen = 1'b0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (tx_level == '0) begin
                seen = 1'b1;
                check("R5", "thre at last move", {31'b0, thre}, 32'd1);
                check("R5", "irq at last move", {31'b0, tx_irq}, 32'd1);
                check("R4", "temt while shifting", {31'b0, temt}, 32'd0);
            end
        end
        wait_idle();

        // Clear pulse with a colliding write (R9)
        stall = 1'b1;
        host_write(8'hC1, 0);
        @(negedge clk);
        host_write(8'hC2, 1);
        host_write(8'hC3, 1);
        check("R9", "level before clear", {27'b0, tx_level}, 32'd2);
        @(negedge clk);
        tx_clear  = 1'b1;
        host_wr   = 1'b1;
        host_data = 8'hC4;
        @(negedge clk);
        tx_clear = 1'b0;
        host_wr  = 1'b0;
        check("R9", "level after clear", {27'b0, tx_level}, 32'd0);
        check("R9", "thre after clear", {31'b0, thre}, 32'd1);
        check("R9", "temt unchanged", {31'b0, temt}, 32'd0);
        check("R9", "irq unchanged", {31'b0, tx_irq}, 32'd0);
        stall = 1'b0;
        wait_idle();

        // Loopback routing (R8)
        loopback = 1'b1;
        host_write(8'hD1, 0);
        @(negedge clk);
        check("R8", "offer in loopback", {31'b0, ser_valid}, 32'd1);
        check("R8", "line held quiet", {31'b0, ser_quiet}, 32'd1);
        host_write(8'hD2, 0);
        wait_idle();
        loopback = 1'b0;
        check("R8", "all bytes delivered", exp_q.size(), 32'd0);

        summary();
        $finish;
    end

endmodule